// File: doc/BRIEF.md
# Shape-Selectable Dual-Port Synchronous RAM

This block is a 4096-bit memory with two independent ports. Each port has its own clock, reset, enable, write enable, address, write data and registered read data. Both ports see the same bit array, but each port picks its own word shape with a static select. One side can fill the array one bit at a time while the other side reads it back sixteen bits at a time.

Every input is sampled only on the port's rising clock edge, reads included. There is no combinational path from address to data. The read register changes one edge after the request. A write also updates the read register, which then shows the word just written. Word A at width W occupies bits A*W up to A*W+W-1 of the shared array. As a result, a word written through one shape sits at a predictable place when it is read through another shape.

The design keeps one bank per port. The stored value is the XOR of the two banks. A write therefore only ever modifies its own port's bank, and no storage element has two writers.

Top module: `shaped_dpram`

## Requirements
- R1: The shape select encodes word width as 0→1 bit, 1→2, 2→4, 3→8, 4→16. Codes 5 to 7 act as 16 bits. Read data bits above the selected width are always zero.
- R2: Word address A at width W covers array bits A*W to A*W+W-1, with bit A*W in read/write data bit 0. Address bits above log2(4096/W) are ignored, so data written with one shape can be read back with any other.
- R3: A read is requested at an edge where enable is high and write enable is low. The addressed word appears on the read data one edge later and stays until the next enabled edge.
- R4: At an edge with enable and write enable both high, the word is stored. After that edge the read data shows the written word, masked to the port width (write-first).
- R5: At an edge with enable low, the port writes nothing and its read data keeps its value.
- R6: A high reset at a port's edge clears only that port's read data to zero. The other port and the stored array are not affected.
- R7: The array holds all zeros before the first write.
- R8: The two ports may both be active at the same edge. Writes to disjoint bits both take effect. A read of bits that the other port writes at that same edge returns the old value.
- R9: Same-edge writes from both ports to overlapping bits leave undefined contents. This case is flagged.
- R10: A write changes only the bits of its own word. All other bits in the array keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| shape_a | input | 3 | Port A word shape select (static) |
| addr_a | input | 12 | Port A word address |
| din_a | input | 16 | Port A write data, low W bits used |
| dout_a | output | 16 | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| shape_b | input | 3 | Port B word shape select (static) |
| addr_b | input | 12 | Port B word address |
| din_b | input | 16 | Port B write data, low W bits used |
| dout_b | output | 16 | Port B registered read data |

## Verification
Each result on either port is due exactly one rising edge after its inputs are sampled: read data, write-first data, reset clearing and enable-low holding all follow that rule. The bench sets inputs between edges and compares both read registers 1 ns after every edge against a behavioural bit-array model. The model computes every port's result from the pre-edge array and then applies the writes. This gives the old-value rule for same-edge accesses from the other port. Writes reach the array at that same edge, so a read one edge later already sees them. Directed cases with literal expected words cover shape crossing, partial rows, address wrap and concurrent writes, followed by long pseudo-random mixed-shape traffic.

// File: rtl/shram_pkg.sv
package shram_pkg;
  localparam int DEF_TOTAL_BITS = 4096;
  localparam int DEF_LANE_W     = 16;

  typedef enum logic [2:0] {
    SHAPE_X1  = 3'd0,
    SHAPE_X2  = 3'd1,
    SHAPE_X4  = 3'd2,
    SHAPE_X8  = 3'd3,
    SHAPE_X16 = 3'd4
  } shape_e;

  // log2 of the word width, saturated at the widest shape
  function automatic int shape_log2(input logic [2:0] code, input int max_log2);
    int s;
    s = int'(code);
    if (s > max_log2) s = max_log2;
    return s;
  endfunction
endpackage

// File: rtl/shram_decode.sv
module shram_decode
  import shram_pkg::*;
#(
  parameter int TOTAL_BITS = DEF_TOTAL_BITS,
  parameter int LANE_W     = DEF_LANE_W,
  localparam int BIT_AW    = $clog2(TOTAL_BITS),
  localparam int LANE_AW   = $clog2(LANE_W),
  localparam int ROW_AW    = BIT_AW - LANE_AW
) (
  input  logic [2:0]         shape,
  input  logic [BIT_AW-1:0]  addr,
  input  logic [LANE_W-1:0]  din,
  output logic [ROW_AW-1:0]  row,
  output logic [LANE_AW-1:0] lane,
  output logic [LANE_W-1:0]  wmask,
  output logic [LANE_W-1:0]  lmask,
  output logic [LANE_W-1:0]  wdata
);
  int                s;
  int                width;
  logic [BIT_AW-1:0] bitaddr;

  always_comb begin
    s       = shape_log2(shape, LANE_AW);
    width   = 1 << s;
    bitaddr = addr << s;
    row     = bitaddr[BIT_AW-1:LANE_AW];
    lane    = bitaddr[LANE_AW-1:0];
    for (int i = 0; i < LANE_W; i++) wmask[i] = (i < width);
    lmask   = wmask << lane;
    wdata   = (din & wmask) << lane;
  end
endmodule

// File: rtl/shram_bank.sv
module shram_bank
  import shram_pkg::*;
#(
  parameter int TOTAL_BITS = DEF_TOTAL_BITS,
  parameter int LANE_W     = DEF_LANE_W,
  localparam int ROWS      = TOTAL_BITS / LANE_W,
  localparam int ROW_AW    = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [ROW_AW-1:0] row,
  input  logic [LANE_W-1:0] lmask,
  input  logic [LANE_W-1:0] wdata,
  input  logic [LANE_W-1:0] peer_at_row,
  input  logic [ROW_AW-1:0] look_row,
  output logic [LANE_W-1:0] own_at_row,
  output logic [LANE_W-1:0] look_val
);
  logic [LANE_W-1:0] mem [ROWS];

  initial begin
    for (int r = 0; r < ROWS; r++) mem[r] = '0;
  end

  // store data XOR peer so that own ^ peer reproduces the written bits
  always_ff @(posedge clk) begin
    if (wr) mem[row] <= (mem[row] & ~lmask) | ((wdata ^ peer_at_row) & lmask);
  end

  assign own_at_row = mem[row];
  assign look_val   = mem[look_row];
endmodule

// File: rtl/shram_rdreg.sv
module shram_rdreg
  import shram_pkg::*;
#(
  parameter int LANE_W     = DEF_LANE_W,
  localparam int LANE_AW   = $clog2(LANE_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               we,
  input  logic [LANE_AW-1:0] lane,
  input  logic [LANE_W-1:0]  wmask,
  input  logic [LANE_W-1:0]  din,
  input  logic [LANE_W-1:0]  row_val,
  output logic [LANE_W-1:0]  dout
);
  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (en) begin
      if (we)     dout <= din & wmask;
      else        dout <= (row_val >> lane) & wmask;
    end
  end

  // R6: reset clears the read register
  a_r6_reset_clears: assert property (@(posedge clk) rst |=> dout == '0);
  // R5: disabled port holds its output
  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout));
  // R1: bits above the selected width stay zero
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    en |=> (dout & ~$past(wmask)) == '0);
endmodule

// File: rtl/shaped_dpram.sv
module shaped_dpram
  import shram_pkg::*;
#(
  parameter int TOTAL_BITS = DEF_TOTAL_BITS,
  parameter int LANE_W     = DEF_LANE_W,
  localparam int BIT_AW    = $clog2(TOTAL_BITS),
  localparam int LANE_AW   = $clog2(LANE_W),
  localparam int ROW_AW    = BIT_AW - LANE_AW
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              en_a,
  input  logic              we_a,
  input  logic [2:0]        shape_a,
  input  logic [BIT_AW-1:0] addr_a,
  input  logic [LANE_W-1:0] din_a,
  output logic [LANE_W-1:0] dout_a,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic              en_b,
  input  logic              we_b,
  input  logic [2:0]        shape_b,
  input  logic [BIT_AW-1:0] addr_b,
  input  logic [LANE_W-1:0] din_b,
  output logic [LANE_W-1:0] dout_b
);
  logic [1:0]              clk_v, rst_v, en_v, we_v, wr_v;
  logic [1:0][2:0]         shape_v;
  logic [1:0][BIT_AW-1:0]  addr_v;
  logic [1:0][LANE_W-1:0]  din_v, dout_v;
  logic [1:0][ROW_AW-1:0]  row_v;
  logic [1:0][LANE_AW-1:0] lane_v;
  logic [1:0][LANE_W-1:0]  wm_v, lm_v, wd_v, own_v, look_v, rowval_v;

  assign clk_v   = {clk_b, clk_a};
  assign rst_v   = {rst_b, rst_a};
  assign en_v    = {en_b, en_a};
  assign we_v    = {we_b, we_a};
  assign shape_v = {shape_b, shape_a};
  assign addr_v  = {addr_b, addr_a};
  assign din_v   = {din_b, din_a};
  assign dout_a  = dout_v[0];
  assign dout_b  = dout_v[1];

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam int PEER = 1 - p;

    assign wr_v[p] = en_v[p] & we_v[p];

    shram_decode #(.TOTAL_BITS(TOTAL_BITS), .LANE_W(LANE_W)) u_dec (
      .shape (shape_v[p]),
      .addr  (addr_v[p]),
      .din   (din_v[p]),
      .row   (row_v[p]),
      .lane  (lane_v[p]),
      .wmask (wm_v[p]),
      .lmask (lm_v[p]),
      .wdata (wd_v[p])
    );

    shram_bank #(.TOTAL_BITS(TOTAL_BITS), .LANE_W(LANE_W)) u_bank (
      .clk         (clk_v[p]),
      .wr          (wr_v[p]),
      .row         (row_v[p]),
      .lmask       (lm_v[p]),
      .wdata       (wd_v[p]),
      .peer_at_row (look_v[PEER]),
      .look_row    (row_v[PEER]),
      .own_at_row  (own_v[p]),
      .look_val    (look_v[p])
    );

    assign rowval_v[p] = own_v[p] ^ look_v[PEER];

    shram_rdreg #(.LANE_W(LANE_W)) u_rd (
      .clk     (clk_v[p]),
      .rst     (rst_v[p]),
      .en      (en_v[p]),
      .we      (we_v[p]),
      .lane    (lane_v[p]),
      .wmask   (wm_v[p]),
      .din     (din_v[p]),
      .row_val (rowval_v[p]),
      .dout    (dout_v[p])
    );
  end

  // R9: both ports writing overlapping bits at the same edge
  a_r9_no_overlap_write: assert property (@(posedge clk_a) disable iff (rst_a)
    !(wr_v[0] && wr_v[1] && row_v[0] == row_v[1] && |(lm_v[0] & lm_v[1])));
  // R4: write-first on each port
  a_r4_write_first_a: assert property (@(posedge clk_a) disable iff (rst_a)
    (en_a && we_a) |=> dout_a == ($past(din_a) & $past(wm_v[0])));
  a_r4_write_first_b: assert property (@(posedge clk_b) disable iff (rst_b)
    (en_b && we_b) |=> dout_b == ($past(din_b) & $past(wm_v[1])));
endmodule

// File: tb/shaped_dpram_test.sv
`timescale 1ns/100ps
module shaped_dpram_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_a, en_a, we_a, rst_b, en_b, we_b;
  logic [2:0]  shape_a, shape_b;
  logic [11:0] addr_a, addr_b;
  logic [15:0] din_a, din_b, dout_a, dout_b;

  shaped_dpram uut (
    .clk_a(clk), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .shape_a(shape_a),
    .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
    .clk_b(clk), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .shape_b(shape_b),
    .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
  );

  int          checks = 0, errors = 0;
  string       req = "R6";
  logic        model [4096];
  logic [15:0] exp_a = '0, exp_b = '0;
  logic [31:0] lf = 32'h1234_5678;

  function automatic int lg(input logic [2:0] c);
    return (c > 3'd4) ? 4 : int'(c);
  endfunction

  function automatic int base_of(input logic [2:0] c, input logic [11:0] a);
    return (int'(a) << lg(c)) % 4096;
  endfunction

  function automatic logic [15:0] mask_of(input logic [2:0] c);
    return 16'((32'd1 << (1 << lg(c))) - 1);
  endfunction

  function automatic logic [15:0] rd_word(input logic [2:0] c, input logic [11:0] a);
    logic [15:0] r = '0;
    for (int i = 0; i < (1 << lg(c)); i++) r[i] = model[base_of(c, a) + i];
    return r;
  endfunction

  task automatic wr_word(input logic [2:0] c, input logic [11:0] a, input logic [15:0] d);
    for (int i = 0; i < (1 << lg(c)); i++) model[base_of(c, a) + i] = d[i];
  endtask

  function automatic logic [15:0] next_out(input logic r, input logic e, input logic w,
      input logic [2:0] c, input logic [11:0] a, input logic [15:0] d, input logic [15:0] cur);
    if (r) return '0;
    if (!e) return cur;
    if (w) return d & mask_of(c);
    return rd_word(c, a);
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string r);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  // one edge: model results from pre-edge array, then writes, then compare
  task automatic tick();
    logic [15:0] na, nb;
    @(posedge clk);
    #1;
    na = next_out(rst_a, en_a, we_a, shape_a, addr_a, din_a, exp_a);
    nb = next_out(rst_b, en_b, we_b, shape_b, addr_b, din_b, exp_b);
    if (en_a && we_a) wr_word(shape_a, addr_a, din_a);
    if (en_b && we_b) wr_word(shape_b, addr_b, din_b);
    exp_a = na;
    exp_b = nb;
    check(dout_a, exp_a, req);
    check(dout_b, exp_b, req);
  endtask

  task automatic set_a(input logic e, input logic w, input logic [2:0] c,
                       input logic [11:0] a, input logic [15:0] d);
    en_a = e; we_a = w; shape_a = c; addr_a = a; din_a = d;
  endtask

  task automatic set_b(input logic e, input logic w, input logic [2:0] c,
                       input logic [11:0] a, input logic [15:0] d);
    en_b = e; we_b = w; shape_b = c; addr_b = a; din_b = d;
  endtask

  function automatic logic [31:0] step_lf(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3: watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) model[i] = 1'b0;
    rst_a = 1'b1; rst_b = 1'b1;
    set_a(0, 0, 3'd4, 0, 0); set_b(0, 0, 3'd4, 0, 0);
    req = "R6"; tick(); tick();
    check(dout_a, 16'h0000, "R6"); check(dout_b, 16'h0000, "R6");
    rst_a = 1'b0; rst_b = 1'b0;

    // R7: fresh array reads zero, R3 one-edge latency
    req = "R7"; set_b(1, 0, 3'd4, 12'd9, 0); tick();
    check(dout_b, 16'h0000, "R7");
    set_b(0, 0, 3'd4, 0, 0); tick();

    // R2 / R4: bitwise fill through x1, read through x16
    req = "R4";
    for (int i = 0; i < 16; i++) begin
      set_a(1, 1, 3'd0, 12'(i), 16'((16'hC3A5 >> i) & 16'h1) | 16'hFFFE);
      tick();
      check(dout_a, 16'((16'hC3A5 >> i) & 16'h1), "R4");
    end
    set_a(0, 0, 3'd0, 0, 0);
    req = "R2"; set_b(1, 0, 3'd4, 12'd0, 0); tick();
    check(dout_b, 16'hC3A5, "R2");

    // R10: nibble write leaves the rest of the row untouched
    req = "R10"; set_b(0, 0, 3'd4, 0, 0);
    set_a(1, 1, 3'd2, 12'd1, 16'h0009); tick();
    set_a(0, 0, 3'd2, 0, 0); set_b(1, 0, 3'd4, 12'd0, 0); tick();
    check(dout_b, 16'hC395, "R10");

    // R1: shape codes, including an out-of-range one
    req = "R1"; set_b(1, 0, 3'd7, 12'd0, 0); tick();
    check(dout_b, 16'hC395, "R1");
    set_b(1, 0, 3'd3, 12'd1, 0); tick();
    check(dout_b, 16'h00C3, "R1");
    set_b(1, 0, 3'd1, 12'd2, 0); tick();
    check(dout_b, 16'h0001, "R1");

    // R2: excess address bits ignored (x2 addr FFF -> bits 4094..4095)
    req = "R2"; set_b(0, 0, 3'd4, 0, 0);
    set_a(1, 1, 3'd1, 12'hFFF, 16'hFFFE); tick();
    set_a(0, 0, 3'd1, 0, 0); set_b(1, 0, 3'd4, 12'hFFF, 0); tick();
    check(dout_b, 16'h8000, "R2");

    // R5: disabled write is dropped and output holds
    req = "R5"; set_b(0, 0, 3'd4, 0, 0);
    set_a(0, 1, 3'd4, 12'd0, 16'hFFFF); tick();
    check(dout_a, 16'h0002, "R5");
    set_a(0, 0, 3'd4, 0, 0); set_b(1, 0, 3'd4, 12'd0, 0); tick();
    check(dout_b, 16'hC395, "R5");

    // R8: concurrent disjoint writes in one row, then read vs peer write
    req = "R8";
    set_a(1, 1, 3'd3, 12'd4, 16'h005A); set_b(1, 1, 3'd3, 12'd5, 16'h003C); tick();
    set_a(0, 0, 3'd3, 0, 0); set_b(1, 0, 3'd4, 12'd2, 0); tick();
    check(dout_b, 16'h3C5A, "R8");
    set_a(1, 0, 3'd4, 12'd2, 0); set_b(1, 1, 3'd3, 12'd4, 16'h0077); tick();
    check(dout_a, 16'h3C5A, "R8");
    set_b(0, 0, 3'd4, 0, 0); tick();
    check(dout_a, 16'h3C77, "R8");

    // R6: reset on A only
    req = "R6"; rst_a = 1'b1; set_b(1, 0, 3'd4, 12'd2, 0); tick();
    check(dout_a, 16'h0000, "R6"); check(dout_b, 16'h3C77, "R6");
    rst_a = 1'b0; set_a(1, 0, 3'd4, 12'd2, 0); tick();
    check(dout_a, 16'h3C77, "R6");

    // R3 / R2: random traffic, one port writes while the other reads
    req = "R3";
    for (int k = 0; k < 3000; k++) begin
      lf = step_lf(lf);
      if (k < 1500) begin
        set_a(lf[0] | lf[1], 1, 3'(lf[4:2] % 5), lf[16:5], lf[31:16]);
        lf = step_lf(lf);
        set_b(lf[0] | lf[1], 0, lf[4:2], lf[16:5], 0);
      end else begin
        set_b(lf[0] | lf[1], 1, 3'(lf[4:2] % 5), lf[16:5], lf[31:16]);
        lf = step_lf(lf);
        set_a(lf[0] | lf[1], lf[2] & lf[3] & 1'b0, lf[6:4], lf[18:7], 0);
      end
      tick();
    end

    set_a(0, 0, 3'd4, 0, 0); set_b(0, 0, 3'd4, 0, 0); tick();
    summary();
    $finish;
  end
endmodule